// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Drive Sequencer

This block sequences the enable commands for the upper and lower switches of a synchronous buck power stage. A PWM request picks which switch should conduct. The sequencer never lets both switches conduct at once. When PWM rises, it drops the lower enable and waits until a digital comparator flag reports that the lower gate has discharged. Only then does it raise the upper enable. When PWM falls, it drops the upper enable and waits for two flags before raising the lower enable: the switch node must be low and the upper gate must be low. A cycle-count timeout turns the lower switch on anyway if those flags never both arrive.

Four override inputs sit above the dead-time logic. An active-low shutdown forces both enables off. A supply-good flag that is false also forces both off. An active-low low-side disable keeps only the lower enable off. A crowbar request beats everything else: it forces the upper enable off and the lower enable on. After any override ends, the sequencer starts again with both switches off and applies the normal dead-time rule. Every input is asynchronous and passes through a synchroniser chain of `SYNC_STAGES` flops.

Top module: `gds_sequencer`

## Requirements
- R1: With shutdown high, supply good, low-side disable high, crowbar low and all feedback flags true, a steady PWM high gives upper=1 and lower=0, and a steady PWM low gives upper=0 and lower=1.
- R2: After PWM falls, the upper enable drops in the same cycle the lower enable would have been allowed to change. The lower enable rises one cycle after the synchronised switch-node-low and upper-gate-low flags are both true.
- R3: If the flags in R2 are not both true, the lower enable rises exactly TMO_CYC = floor(CLK_HZ/1000 * TIMEOUT_NS / 1e6) cycles after the PWM fall takes effect. That is 3+17 = 20 clock edges after the input change, at 50 MHz and 350 ns.
- R4: After PWM rises, the lower enable drops first. The upper enable rises only one cycle after the synchronised lower-gate-low flag is true; while that flag stays false, both enables remain 0.
- R5: While the shutdown input (active low) is 0 and crowbar is 0, both enables are 0.
- R6: While the low-side disable input (active low) is 0 and crowbar is 0, the lower enable is 0. The upper enable still follows PWM.
- R7: While the supply-good flag is 0 and crowbar is 0, both enables are 0.
- R8: While crowbar is 1, the upper enable is 0 and the lower enable is 1. This holds whatever the state of PWM, shutdown, low-side disable, supply-good and the feedback flags.
- R9: Each PWM fall restarts the timeout from zero. Time spent low in an earlier, shorter low pulse does not shorten the next timeout.
- R10: When crowbar, shutdown or lockout ends, both enables start at 0. With PWM high, the upper enable waits for the lower-gate-low flag.
- R11: The upper and lower enables are never 1 in the same cycle.
- R12: An input change reaches the state register SYNC_STAGES+1 clock edges later. That is 3 edges with the default of 2 stages, so crowbar asserted while the upper switch is on shows upper=1 after 2 edges and upper=0, lower=1 after 3 edges.
- R13: While reset is asserted, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM request: 1 selects the upper switch, 0 the lower |
| shdn_n | input | 1 | Active-low global shutdown |
| lsoff_n | input | 1 | Active-low lower-switch disable |
| clamp_req | input | 1 | Crowbar request, highest priority |
| pgood | input | 1 | Supply-good flag, 0 means lockout |
| sw_low | input | 1 | Comparator flag: switch node is low |
| hg_low | input | 1 | Comparator flag: upper gate is discharged |
| lg_low | input | 1 | Comparator flag: lower gate is discharged |
| hs_drv | output | 1 | Upper switch enable |
| ls_drv | output | 1 | Lower switch enable |

## Verification
Every input goes through two synchroniser flops and then the state register. Any change in PWM or an override therefore becomes visible on the enables after three clock edges. A step gated by a feedback flag takes one edge more, and a timeout takes three edges plus TMO_CYC. The bench drives inputs on falling edges and counts rising edges to each due point. It checks one edge early that the enable has not yet moved, then checks the edge where it must move. Steady-state combinations are held long enough for any timeout to finish before they are compared.

// File: rtl/gds_pkg.sv
package gds_pkg;

   typedef enum logic [2:0] {
      ST_OFF     = 3'd0,
      ST_HS_WAIT = 3'd1,
      ST_HS_ON   = 3'd2,
      ST_LS_WAIT = 3'd3,
      ST_LS_ON   = 3'd4,
      ST_CLAMP   = 3'd5
   } gds_state_e;

   // bit positions of the synchronised input bundle
   localparam int unsigned IX_PWM   = 0;
   localparam int unsigned IX_SHDN  = 1;
   localparam int unsigned IX_LSOFF = 2;
   localparam int unsigned IX_CLAMP = 3;
   localparam int unsigned IX_PGOOD = 4;
   localparam int unsigned IX_SWLO  = 5;
   localparam int unsigned IX_HGLO  = 6;
   localparam int unsigned IX_LGLO  = 7;
   localparam int unsigned N_INPUTS = 8;

   function automatic int unsigned tmo_cycles(input int unsigned clk_hz,
                                              input int unsigned tmo_ns);
      longint unsigned prod;
      prod = longint'(clk_hz / 1000) * longint'(tmo_ns);
      return int'(prod / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/gds_sync.sv
module gds_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gds_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/gds_timer.sv
module gds_timer #(
   parameter int unsigned TMO_CYC = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int unsigned CW = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
   localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

   generate
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("gds_timer: TMO_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   // R3: the count stays inside its window and restarts whenever the wait ends
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);

endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
   import gds_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_INPUTS-1:0] in_s,
   input  logic                tmo_hit,
   output logic                wait_low,
   output logic                hs_drv,
   output logic                ls_drv
);

   gds_state_e state, nxt;

   logic pwm, shdn, lsoff, clamp, pgood, swlo, hglo, lglo;
   assign pwm   = in_s[IX_PWM];
   assign shdn  = in_s[IX_SHDN];
   assign lsoff = in_s[IX_LSOFF];
   assign clamp = in_s[IX_CLAMP];
   assign pgood = in_s[IX_PGOOD];
   assign swlo  = in_s[IX_SWLO];
   assign hglo  = in_s[IX_HGLO];
   assign lglo  = in_s[IX_LGLO];

   always_comb begin
      nxt = state;
      if (clamp) begin
         nxt = ST_CLAMP;
      end else if (!shdn || !pgood) begin
         nxt = ST_OFF;
      end else begin
         unique case (state)
            ST_OFF:     nxt = pwm ? ST_HS_WAIT : ST_LS_WAIT;
            ST_HS_WAIT: if (!pwm) nxt = ST_LS_WAIT;
                        else if (lglo) nxt = ST_HS_ON;
            ST_HS_ON:   if (!pwm) nxt = ST_LS_WAIT;
            ST_LS_WAIT: if (pwm) nxt = ST_HS_WAIT;
                        else if ((swlo && hglo) || tmo_hit) nxt = ST_LS_ON;
            ST_LS_ON:   if (pwm) nxt = ST_HS_WAIT;
            ST_CLAMP:   nxt = ST_OFF;
            default:    nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= nxt;
   end

   assign wait_low = (state == ST_LS_WAIT);
   assign hs_drv   = (state == ST_HS_ON);
   assign ls_drv   = (state == ST_CLAMP) || ((state == ST_LS_ON) && lsoff);

   // R11: never both enables
   p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_drv && ls_drv));
   // R4: upper enable only rises after lower gate reported low
   p_hs_after_lg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_drv) |-> $past(lglo) && $past(pwm));
   // R2/R3: lower enable from the wait state needs both flags or the timeout
   p_ls_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LS_ON && $past(state == ST_LS_WAIT)) |->
         ($past(swlo && hglo) || $past(tmo_hit)));
   // R8: crowbar forces lower on, upper off
   p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clamp |=> (ls_drv && !hs_drv));
   // R5: shutdown forces both off
   p_shdn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!shdn && !clamp) |=> (!hs_drv && !ls_drv));
   // R7: lockout forces both off
   p_uvlo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgood && !clamp) |=> (!hs_drv && !ls_drv));
   // R10: leaving an override never jumps straight to a driven switch
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(state == ST_CLAMP || state == ST_OFF) |-> !hs_drv);

endmodule

// File: rtl/gds_sequencer.sv
module gds_sequencer
   import gds_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 50_000_000,
   parameter int unsigned TIMEOUT_NS  = 350,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_in,
   input  logic shdn_n,
   input  logic lsoff_n,
   input  logic clamp_req,
   input  logic pgood,
   input  logic sw_low,
   input  logic hg_low,
   input  logic lg_low,
   output logic hs_drv,
   output logic ls_drv
);

   localparam int unsigned TMO_CYC = tmo_cycles(CLK_HZ, TIMEOUT_NS);

   generate
      if (TIMEOUT_NS < 150 || TIMEOUT_NS > 600) begin : g_bad_window
         $error("gds_sequencer: TIMEOUT_NS outside 150..600");
      end
      if (TMO_CYC < 2) begin : g_bad_clock
         $error("gds_sequencer: clock too slow for timeout resolution");
      end
   endgenerate

   logic [N_INPUTS-1:0] raw, in_s;
   logic                run, tmo_hit;

   always_comb begin
      raw            = '0;
      raw[IX_PWM]    = pwm_in;
      raw[IX_SHDN]   = shdn_n;
      raw[IX_LSOFF]  = lsoff_n;
      raw[IX_CLAMP]  = clamp_req;
      raw[IX_PGOOD]  = pgood;
      raw[IX_SWLO]   = sw_low;
      raw[IX_HGLO]   = hg_low;
      raw[IX_LGLO]   = lg_low;
   end

   gds_sync #(.WIDTH(N_INPUTS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (in_s)
   );

   gds_timer #(.TMO_CYC(TMO_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .expired (tmo_hit)
   );

   gds_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_s     (in_s),
      .tmo_hit  (tmo_hit),
      .wait_low (run),
      .hs_drv   (hs_drv),
      .ls_drv   (ls_drv)
   );

endmodule

// File: tb/sim_gds_sequencer.sv
module sim_gds_sequencer;

   localparam int TMO = (50_000 * 350) / 1_000_000; // 17 cycles at 50 MHz
   localparam int LAT = 3;                          // 2 sync flops + state
   localparam int NV  = 15;

   // {clamp,pgood,shdn,lsoff,pwm,sw,hg,lg, exp_hs,exp_ls, req[3:0]}
   localparam logic [13:0] VEC [NV] = '{
      {8'b01111111, 2'b10, 4'd1},   // R1 pwm high
      {8'b01110111, 2'b01, 4'd1},   // R1 pwm low
      {8'b01111111, 2'b10, 4'd1},   // R1 pwm high again
      {8'b01011111, 2'b00, 4'd5},   // R5 shutdown, pwm high
      {8'b01010111, 2'b00, 4'd5},   // R5 shutdown, pwm low
      {8'b01100111, 2'b00, 4'd6},   // R6 lower disabled, pwm low
      {8'b01101111, 2'b10, 4'd6},   // R6 lower disabled, pwm high
      {8'b00111111, 2'b00, 4'd7},   // R7 lockout, pwm high
      {8'b00110111, 2'b00, 4'd7},   // R7 lockout, pwm low
      {8'b11111111, 2'b01, 4'd8},   // R8 crowbar, pwm high
      {8'b10001000, 2'b01, 4'd8},   // R8 crowbar over every override
      {8'b01110001, 2'b01, 4'd3},   // R3 no feedback, timeout fires
      {8'b01111110, 2'b00, 4'd4},   // R4 lower gate not low, upper waits
      {8'b01111111, 2'b10, 4'd4},   // R4 lower gate low, upper on
      {8'b01110101, 2'b01, 4'd2}    // R2 only switch node low, timeout path
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_in = 1'b0, shdn_n = 1'b1, lsoff_n = 1'b1, clamp_req = 1'b0;
   logic pgood = 1'b1, sw_low = 1'b1, hg_low = 1'b1, lg_low = 1'b1;
   logic hs_drv, ls_drv;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   gds_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .shdn_n(shdn_n),
      .lsoff_n(lsoff_n), .clamp_req(clamp_req), .pgood(pgood),
      .sw_low(sw_low), .hg_low(hg_low), .lg_low(lg_low),
      .hs_drv(hs_drv), .ls_drv(ls_drv)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic eh, input logic el);
      n_chk++;
      if (hs_drv !== eh || ls_drv !== el) begin
         n_bad++;
         $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b",
                  req, hs_drv, ls_drv, eh, el);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R13 in reset", 1'b0, 1'b0);
      step(3);
      check("R13 held reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      step(30);

      for (int i = 0; i < NV; i++) begin
         {clamp_req, pgood, shdn_n, lsoff_n, pwm_in, sw_low, hg_low, lg_low}
            = VEC[i][13:6];
         step(40);
         check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
               VEC[i][5], VEC[i][4]);
      end

      // back to normal, lower switch on
      {clamp_req, pgood, shdn_n, lsoff_n, pwm_in, sw_low, hg_low, lg_low} = 8'b01110111;
      step(40);

      // R12 / R4: rising edge latency
      pwm_in = 1'b1;
      step(LAT);
      check("R4 R12 lower released, upper waiting", 1'b0, 1'b0);
      step(1);
      check("R4 upper on after lg flag", 1'b1, 1'b0);

      // R2: falling edge with feedback present
      pwm_in = 1'b0;
      step(LAT);
      check("R2 upper released, lower waiting", 1'b0, 1'b0);
      step(1);
      check("R2 lower on after both flags", 1'b0, 1'b1);

      // R3: exact timeout
      pwm_in = 1'b1;
      step(10);
      sw_low = 1'b0; hg_low = 1'b0;
      pwm_in = 1'b0;
      step(LAT + TMO - 1);
      check("R3 one edge before timeout", 1'b0, 1'b0);
      step(1);
      check("R3 timeout asserts lower", 1'b0, 1'b1);

      // R9: short low pulse does not leave a stale count
      pwm_in = 1'b1;
      step(10);
      pwm_in = 1'b0;
      step(10);
      pwm_in = 1'b1;
      step(5);
      pwm_in = 1'b0;
      step(LAT + TMO - 1);
      check("R9 fresh timeout not yet expired", 1'b0, 1'b0);
      step(1);
      check("R9 fresh timeout expires", 1'b0, 1'b1);

      // R8 / R12: crowbar latency from upper on
      sw_low = 1'b1; hg_low = 1'b1;
      pwm_in = 1'b1;
      step(10);
      clamp_req = 1'b1;
      step(2);
      check("R12 crowbar not yet seen", 1'b1, 1'b0);
      step(1);
      check("R8 crowbar takes effect", 1'b0, 1'b1);

      // R10: restart after crowbar waits for lower gate
      lg_low = 1'b0;
      step(10);
      clamp_req = 1'b0;
      step(10);
      check("R10 restart holds both off", 1'b0, 1'b0);
      lg_low = 1'b1;
      step(LAT);
      check("R10 upper after lg flag", 1'b1, 1'b0);

      // R6: low-side disable released while in lower-on state
      lsoff_n = 1'b0;
      pwm_in = 1'b0;
      step(40);
      check("R6 lower held off", 1'b0, 1'b0);
      lsoff_n = 1'b1;
      step(LAT);
      check("R6 lower resumes", 1'b0, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule